// File: doc/BRIEF.md
# System Control Register File

This block holds a small set of 32-bit processor control and identification registers and serves them through one shared index. A single index selects the register. A write strobe with write data updates the register at the next clock edge. A read strobe returns that register's value combinationally on the same index. Each register applies its own write policy:

- plain storage;
- a masked keep;
- a merge that preserves part of the old value;
- a silent drop;
- an alias that ORs selected bits into a parent register.

Some indices return constants or values computed from the core number and the uniprocessor input.

There are two resets. The power-on reset `por_n` is asynchronous and seeds every register, including the identity register and the control-template register. The warm reset `rst_n` is synchronous and puts every register back to its defined value, except those two, which keep their contents. A one-cycle `tlb_stale` pulse tells the neighbouring translation logic that cached control state must be dropped. A read of an index that has no register returns zero and raises `rd_err` for one cycle.

Top module: `sysctl_regfile`

## Requirements
- R1: Power-on reset loads the identity register (index 0) with ID_DEFAULT and the control template (index 2) with TPL_DEFAULT. Both keep their contents through a warm reset, and they change only on a write to their own index.
- R2: A warm reset gives the following values:
  - control (index 1) = (template & 0x48002000) | 0x00C00070;
  - status (index 3) = 0x00000010, which is user mode in bits 4:0;
  - event mailbox (index 10) = 1;
  - coprocessor access (index 5), FP status (index 6) and FP control (index 9) = 0.
  
  A write in the same cycle as a warm reset is lost, and no `tlb_stale` pulse follows it.
- R3: A control write stores the data but always keeps the old bit 27 (the non-maskable fast-interrupt bit). `tlb_stale` is high in the next cycle.
- R4: A coprocessor access write stores data & 0x80F00000. The kept bits are two 2-bit enable fields at 23:20 and a SIMD-disable bit at 31.
- R5: An FP control write changes only bits 30:29. Every other bit keeps its old value.
- R6: An FP status write stores (data & 0xFFF7009F) | (old & ~0xFFF7009F). The mask covers:
  - the cumulative flags in bits 4:0 and 7;
  - length at 18:16 and stride at 21:20;
  - rounding at 23:22;
  - flush-to-zero at 24, default-NaN at 25 and alternative half precision at 26;
  - saturation at 27;
  - NZCV at 31:28.
- R7: Writes to the following indices are dropped, and their reads are unchanged:
  - TLB type (11, reads TLBTYPE_VAL);
  - media features 0 and 1 (12, 13);
  - multiprocessor ID (14);
  - FP identity (15);
  - cache type (16);
  - cache level (17).
- R8: Alias writes OR into a parent register, and a read of an alias returns its parent:
  - a write to index 4 ORs data & 0x08000000 into status;
  - a write to index 7 ORs data & 0x08000000 into FP status;
  - a write to index 8 ORs data & 0x0000009F into FP status.
- R9: Index 14 reads 0x80000000 | core_id, with bit 30 also set when `uniproc` is 1.
- R10: Index 16 reads 0x86468006 and index 17 reads 0x00200000.
- R11: A status write pulses `tlb_stale` in the next cycle only when bits 4:0 change. A write to the status alias never pulses it.
- R12: A read strobe on an index from 18 to 31 returns 0 and sets `rd_err` for exactly the next cycle. A read of a valid index leaves `rd_err` low.
- R13: Writes take effect at the clock edge. A read in the same cycle as a write to the same index returns the old value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| rst_n | input | 1 | Synchronous warm reset, active low |
| core_id | input | CORE_W | Core number reported by index 14 |
| uniproc | input | 1 | High when the system has a single processor |
| idx | input | 5 | Register index for both read and write |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, used only for error reporting |
| rd_data | output | 32 | Combinational read value at `idx` |
| rd_err | output | 1 | One-cycle flag after a read of an unimplemented index |
| tlb_stale | output | 1 | One-cycle translation-invalidate pulse |

## Verification
Two functions can fall in the same cycle, and the bench provokes each collision on purpose.

- **Read and write on one index.** The bench raises both strobes on the mailbox index in one cycle. The read must return the pre-write value, and a read in the following cycle must return the new value.
- **Warm reset and control write.** The bench holds the warm reset while it strobes a control write. The control register must come out at its template-derived reset value, and `tlb_stale` must stay low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

    localparam int DW   = 32;
    localparam int IX_W = 5;

    // register index map
    localparam logic [IX_W-1:0] IX_MAINID  = 5'd0;
    localparam logic [IX_W-1:0] IX_CTRL    = 5'd1;
    localparam logic [IX_W-1:0] IX_TPL     = 5'd2;
    localparam logic [IX_W-1:0] IX_PSR     = 5'd3;
    localparam logic [IX_W-1:0] IX_PSRSAT  = 5'd4;
    localparam logic [IX_W-1:0] IX_ACCESS  = 5'd5;
    localparam logic [IX_W-1:0] IX_FPSTAT  = 5'd6;
    localparam logic [IX_W-1:0] IX_FPSATAL = 5'd7;
    localparam logic [IX_W-1:0] IX_FPEXCAL = 5'd8;
    localparam logic [IX_W-1:0] IX_FPCTL   = 5'd9;
    localparam logic [IX_W-1:0] IX_MAILBOX = 5'd10;
    localparam logic [IX_W-1:0] IX_TLBTYPE = 5'd11;
    localparam logic [IX_W-1:0] IX_MEDIA0  = 5'd12;
    localparam logic [IX_W-1:0] IX_MEDIA1  = 5'd13;
    localparam logic [IX_W-1:0] IX_MPID    = 5'd14;
    localparam logic [IX_W-1:0] IX_FPID    = 5'd15;
    localparam logic [IX_W-1:0] IX_CTYPE   = 5'd16;
    localparam logic [IX_W-1:0] IX_CLEVEL  = 5'd17;
    localparam int              N_IMPL     = 18;

    // write policy masks
    localparam logic [DW-1:0] NMFI_BIT    = 32'h0800_0000;
    localparam logic [DW-1:0] CTRL_TPLMSK = 32'h4800_2000;
    localparam logic [DW-1:0] CTRL_ONES   = 32'h00C0_0070;
    localparam logic [DW-1:0] ACC_MASK    = 32'h80F0_0000;
    localparam logic [DW-1:0] FPCTL_MASK  = 32'h6000_0000;
    localparam logic [DW-1:0] FPSTAT_MASK = 32'hFFF7_009F;
    localparam logic [DW-1:0] SAT_BIT     = 32'h0800_0000;
    localparam logic [DW-1:0] FPEXC_BITS  = 32'h0000_009F;
    localparam logic [4:0]    MODE_USER   = 5'h10;

    // fixed identification values
    localparam logic [DW-1:0] MPID_BASE   = 32'h8000_0000;
    localparam logic [DW-1:0] MPID_UP     = 32'h4000_0000;
    localparam logic [DW-1:0] CTYPE_VAL   = 32'h8646_8006;
    localparam logic [DW-1:0] CLEVEL_VAL  = 32'h0020_0000;

    typedef struct packed {
        logic [DW-1:0] mainid;
        logic [DW-1:0] tpl;
        logic [DW-1:0] ctrl;
        logic [DW-1:0] psr;
        logic [DW-1:0] access;
        logic [DW-1:0] fpstat;
        logic [DW-1:0] fpctl;
        logic [DW-1:0] mailbox;
    } sys_regs_t;

    typedef struct packed {
        sys_regs_t regs;
        logic      stale;
        logic      rderr;
    } sys_state_t;

endpackage

// File: rtl/sysctl_wr_merge.sv
module sysctl_wr_merge
    import sysctl_pkg::*;
(
    input  sys_regs_t        cur,
    input  logic             wr_en,
    input  logic [IX_W-1:0]  idx,
    input  logic [DW-1:0]    data,
    output sys_regs_t        nxt,
    output logic             inval
);
    always_comb begin
        nxt   = cur;
        inval = 1'b0;
        if (wr_en) begin
            case (idx)
                IX_MAINID: nxt.mainid = data;
                IX_TPL:    nxt.tpl    = data;
                IX_CTRL: begin
                    nxt.ctrl = (data & ~NMFI_BIT) | (cur.ctrl & NMFI_BIT);
                    inval    = 1'b1;
                end
                IX_PSR: begin
                    nxt.psr = data;
                    inval   = (data[4:0] != cur.psr[4:0]);
                end
                IX_PSRSAT:  nxt.psr    = cur.psr | (data & SAT_BIT);
                IX_ACCESS:  nxt.access = data & ACC_MASK;
                IX_FPSTAT:  nxt.fpstat = (data & FPSTAT_MASK) | (cur.fpstat & ~FPSTAT_MASK);
                IX_FPSATAL: nxt.fpstat = cur.fpstat | (data & SAT_BIT);
                IX_FPEXCAL: nxt.fpstat = cur.fpstat | (data & FPEXC_BITS);
                IX_FPCTL:   nxt.fpctl  = (data & FPCTL_MASK) | (cur.fpctl & ~FPCTL_MASK);
                IX_MAILBOX: nxt.mailbox = data;
                default: ; // read-only, identity and unimplemented indices drop writes
            endcase
        end
    end
endmodule

// File: rtl/sysctl_rd_mux.sv
module sysctl_rd_mux
    import sysctl_pkg::*;
#(
    parameter int              CORE_W      = 8,
    parameter logic [DW-1:0]   TLBTYPE_VAL = 32'h0000_0001,
    parameter logic [DW-1:0]   MEDIA0_VAL  = 32'h1011_0222,
    parameter logic [DW-1:0]   MEDIA1_VAL  = 32'h1111_1111,
    parameter logic [DW-1:0]   FPID_VAL    = 32'h4104_30A0
) (
    input  sys_regs_t          st,
    input  logic [IX_W-1:0]    idx,
    input  logic [CORE_W-1:0]  core_id,
    input  logic               uniproc,
    output logic [DW-1:0]      data,
    output logic               hit
);
    logic [DW-1:0] mpid;

    always_comb begin
        mpid = MPID_BASE | DW'(core_id);
        if (uniproc) mpid = mpid | MPID_UP;
    end

    always_comb begin
        hit  = 1'b1;
        data = '0;
        case (idx)
            IX_MAINID:                          data = st.mainid;
            IX_TPL:                             data = st.tpl;
            IX_CTRL:                            data = st.ctrl;
            IX_PSR, IX_PSRSAT:                  data = st.psr;
            IX_ACCESS:                          data = st.access;
            IX_FPSTAT, IX_FPSATAL, IX_FPEXCAL:  data = st.fpstat;
            IX_FPCTL:                           data = st.fpctl;
            IX_MAILBOX:                         data = st.mailbox;
            IX_TLBTYPE:                         data = TLBTYPE_VAL;
            IX_MEDIA0:                          data = MEDIA0_VAL;
            IX_MEDIA1:                          data = MEDIA1_VAL;
            IX_MPID:                            data = mpid;
            IX_FPID:                            data = FPID_VAL;
            IX_CTYPE:                           data = CTYPE_VAL;
            IX_CLEVEL:                          data = CLEVEL_VAL;
            default:                            hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
    import sysctl_pkg::*;
#(
    parameter int            CORE_W      = 8,
    parameter logic [31:0]   ID_DEFAULT  = 32'h5A0C_0001,
    parameter logic [31:0]   TPL_DEFAULT = 32'h4800_2000,
    parameter logic [31:0]   TLBTYPE_VAL = 32'h0000_0001,
    parameter logic [31:0]   MEDIA0_VAL  = 32'h1011_0222,
    parameter logic [31:0]   MEDIA1_VAL  = 32'h1111_1111,
    parameter logic [31:0]   FPID_VAL    = 32'h4104_30A0
) (
    input  logic              clk,
    input  logic              por_n,
    input  logic              rst_n,
    input  logic [CORE_W-1:0] core_id,
    input  logic              uniproc,
    input  logic [4:0]        idx,
    input  logic              wr_en,
    input  logic [31:0]       wr_data,
    input  logic              rd_en,
    output logic [31:0]       rd_data,
    output logic              rd_err,
    output logic              tlb_stale
);
    localparam logic [DW-1:0] CTRL_POR = (TPL_DEFAULT & CTRL_TPLMSK) | CTRL_ONES;

    sys_state_t s_d, s_q;
    sys_regs_t  st_q, merged;
    logic       wr_inval;
    logic       rd_hit;

    assign st_q = s_q.regs;

    sysctl_wr_merge u_merge (
        .cur   (st_q),
        .wr_en (wr_en),
        .idx   (idx),
        .data  (wr_data),
        .nxt   (merged),
        .inval (wr_inval)
    );

    sysctl_rd_mux #(
        .CORE_W      (CORE_W),
        .TLBTYPE_VAL (TLBTYPE_VAL),
        .MEDIA0_VAL  (MEDIA0_VAL),
        .MEDIA1_VAL  (MEDIA1_VAL),
        .FPID_VAL    (FPID_VAL)
    ) u_rd (
        .st      (st_q),
        .idx     (idx),
        .core_id (core_id),
        .uniproc (uniproc),
        .data    (rd_data),
        .hit     (rd_hit)
    );

    always_comb begin
        s_d       = s_q;
        s_d.regs  = merged;
        s_d.stale = wr_en & wr_inval;
        s_d.rderr = rd_en & ~rd_hit;
        if (!rst_n) begin
            // warm reset: identity and template survive
            s_d.regs.ctrl    = (st_q.tpl & CTRL_TPLMSK) | CTRL_ONES;
            s_d.regs.psr     = {{(DW-5){1'b0}}, MODE_USER};
            s_d.regs.access  = '0;
            s_d.regs.fpstat  = '0;
            s_d.regs.fpctl   = '0;
            s_d.regs.mailbox = 32'd1;
            s_d.regs.mainid  = st_q.mainid;
            s_d.regs.tpl     = st_q.tpl;
            s_d.stale        = 1'b0;
            s_d.rderr        = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q.regs.mainid  <= ID_DEFAULT;
            s_q.regs.tpl     <= TPL_DEFAULT;
            s_q.regs.ctrl    <= CTRL_POR;
            s_q.regs.psr     <= {{(DW-5){1'b0}}, MODE_USER};
            s_q.regs.access  <= '0;
            s_q.regs.fpstat  <= '0;
            s_q.regs.fpctl   <= '0;
            s_q.regs.mailbox <= 32'd1;
            s_q.stale        <= 1'b0;
            s_q.rderr        <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign rd_err    = s_q.rderr;
    assign tlb_stale = s_q.stale;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
    import sysctl_pkg::*;
(
    input logic        clk,
    input logic        por_n,
    input logic        rst_n,
    input logic [4:0]  idx,
    input logic        wr_en,
    input logic        rd_en,
    input logic        rd_err,
    input logic        tlb_stale,
    input sys_regs_t   st_q
);
    assert_mainid_hold_R1: assert property (@(posedge clk) disable iff (!por_n)
        !(rst_n && wr_en && idx == IX_MAINID) |=> $stable(st_q.mainid));

    assert_nmfi_keep_R3: assert property (@(posedge clk) disable iff (!por_n)
        (rst_n && wr_en && idx == IX_CTRL) |=> st_q.ctrl[27] == $past(st_q.ctrl[27]));

    assert_access_mask_R4: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.access & ~ACC_MASK) == '0);

    assert_fpctl_keep_R5: assert property (@(posedge clk) disable iff (!por_n)
        rst_n |=> (st_q.fpctl & ~FPCTL_MASK) == ($past(st_q.fpctl) & ~FPCTL_MASK));

    // stale pulse only from a control write or a status write (R3, R11)
    assert_stale_src_R11: assert property (@(posedge clk) disable iff (!por_n)
        tlb_stale |-> ($past(wr_en && rst_n) && ($past(idx) == IX_CTRL || $past(idx) == IX_PSR)));

    assert_err_src_R12: assert property (@(posedge clk) disable iff (!por_n)
        rd_err |-> ($past(rd_en && rst_n) && $past(idx) >= 5'(N_IMPL)));
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
    .clk       (clk),
    .por_n     (por_n),
    .rst_n     (rst_n),
    .idx       (idx),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .rd_err    (rd_err),
    .tlb_stale (tlb_stale),
    .st_q      (st_q)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 5000;

    logic        clk = 1'b0;
    logic        por_n = 1'b0, rst_n = 1'b0;
    logic [7:0]  core_id = 8'h03;
    logic        uniproc = 1'b1;
    logic [4:0]  idx = '0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        rd_err, tlb_stale;

    int tests = 0, fails = 0, cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int          due;
        logic [31:0] exp;
        int          sel;   // 0 rd_data, 1 rd_err, 2 tlb_stale
        string       tag;
    } item_t;
    item_t sb[$];

    sysctl_regfile u_dut (
        .clk(clk), .por_n(por_n), .rst_n(rst_n), .core_id(core_id), .uniproc(uniproc),
        .idx(idx), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
        .rd_data(rd_data), .rd_err(rd_err), .tlb_stale(tlb_stale)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic void push(int due, logic [31:0] exp, int sel, string tag);
        item_t it;
        it.due = due; it.exp = exp; it.sel = sel; it.tag = tag;
        sb.push_back(it);
    endfunction

    // monitor: compares items as their cycle arrives
    initial begin
        forever begin
            @(negedge clk);
            #2;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [31:0] act;
                it = sb.pop_front();
                case (it.sel)
                    0: act = rd_data;
                    1: act = {31'd0, rd_err};
                    default: act = {31'd0, tlb_stale};
                endcase
                tests++;
                if (act !== it.exp) begin
                    fails++;
                    $display("FAIL %s sel=%0d actual=%h expected=%h", it.tag, it.sel, act, it.exp);
                end
            end
        end
    end

    task automatic wr(logic [4:0] i, logic [31:0] d, logic stale, string tag);
        @(negedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b0; idx = i; wr_data = d;
        push(cyc + 1, {31'd0, stale}, 2, tag);
    endtask

    task automatic rd(logic [4:0] i, logic [31:0] exp, logic err, string tag);
        @(negedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b1; idx = i;
        push(cyc, exp, 0, tag);
        push(cyc + 1, {31'd0, err}, 1, tag);
    endtask

    task automatic idle();
        @(negedge clk); #1;
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;

        // R1 / R2 reset state
        rd(5'd0,  32'h5A0C_0001, 1'b0, "R1 identity after power-on");
        rd(5'd2,  32'h4800_2000, 1'b0, "R1 template after power-on");
        rd(5'd1,  32'h48C0_2070, 1'b0, "R2 control reset");
        rd(5'd3,  32'h0000_0010, 1'b0, "R2 status user mode");
        rd(5'd10, 32'h0000_0001, 1'b0, "R2 mailbox");
        rd(5'd5,  32'h0,         1'b0, "R2 access zero");
        rd(5'd6,  32'h0,         1'b0, "R2 fp status zero");
        rd(5'd9,  32'h0,         1'b0, "R2 fp control zero");

        // R10 / R9 identity reads
        rd(5'd16, 32'h8646_8006, 1'b0, "R10 cache type");
        rd(5'd17, 32'h0020_0000, 1'b0, "R10 cache level");
        rd(5'd14, 32'hC000_0003, 1'b0, "R9 mpid uniproc");
        @(negedge clk); uniproc = 1'b0;
        rd(5'd14, 32'h8000_0003, 1'b0, "R9 mpid multiproc");

        // R3 control writes
        wr(5'd1, 32'h0000_0000, 1'b1, "R3 ctrl write stale");
        rd(5'd1, 32'h0800_0000, 1'b0, "R3 nmfi kept set");
        wr(5'd1, 32'hFFFF_FFFF, 1'b1, "R3 ctrl write stale 2");
        rd(5'd1, 32'hFFFF_FFFF, 1'b0, "R3 ctrl all ones");

        // R4 access mask
        wr(5'd5, 32'hFFFF_FFFF, 1'b0, "R4 access write");
        rd(5'd5, 32'h80F0_0000, 1'b0, "R4 access ones");
        wr(5'd5, 32'h1234_5678, 1'b0, "R4 access write 2");
        rd(5'd5, 32'h0030_0000, 1'b0, "R4 access pattern");

        // R5 fp control
        wr(5'd9, 32'hFFFF_FFFF, 1'b0, "R5 fpctl write");
        rd(5'd9, 32'h6000_0000, 1'b0, "R5 fpctl bits 30:29");
        wr(5'd9, 32'h0000_0000, 1'b0, "R5 fpctl clear");
        rd(5'd9, 32'h0000_0000, 1'b0, "R5 fpctl cleared");

        // R6 fp status
        wr(5'd6, 32'hFFFF_FFFF, 1'b0, "R6 fpstat write");
        rd(5'd6, 32'hFFF7_009F, 1'b0, "R6 fpstat mask");
        wr(5'd6, 32'h0000_0000, 1'b0, "R6 fpstat clear");
        rd(5'd6, 32'h0000_0000, 1'b0, "R6 fpstat cleared");

        // R8 aliases
        wr(5'd4, 32'hFFFF_FFFF, 1'b0, "R8 status alias no stale");
        rd(5'd3, 32'h0800_0010, 1'b0, "R8 status sat merged");
        wr(5'd7, 32'hFFFF_FFFF, 1'b0, "R8 fp sat alias");
        rd(5'd6, 32'h0800_0000, 1'b0, "R8 fp sat merged");
        wr(5'd8, 32'hFFFF_FFFF, 1'b0, "R8 fp exc alias");
        rd(5'd7, 32'h0800_009F, 1'b0, "R8 alias reads parent");

        // R11 status mode change
        wr(5'd3, 32'h0800_0010, 1'b0, "R11 same mode no stale");
        wr(5'd3, 32'h0000_0013, 1'b1, "R11 mode change stale");
        rd(5'd3, 32'h0000_0013, 1'b0, "R11 status value");

        // R7 ignored writes
        wr(5'd11, 32'hDEAD_BEEF, 1'b0, "R7 tlbtype write");
        rd(5'd11, 32'h0000_0001, 1'b0, "R7 tlbtype unchanged");
        wr(5'd12, 32'hDEAD_BEEF, 1'b0, "R7 media0 write");
        rd(5'd12, 32'h1011_0222, 1'b0, "R7 media0 unchanged");
        wr(5'd14, 32'h0000_0000, 1'b0, "R7 mpid write");
        rd(5'd14, 32'h8000_0003, 1'b0, "R7 mpid unchanged");
        wr(5'd15, 32'h0000_0000, 1'b0, "R7 fpid write");
        rd(5'd15, 32'h4104_30A0, 1'b0, "R7 fpid unchanged");
        wr(5'd16, 32'h0000_0000, 1'b0, "R7 cache type write");
        rd(5'd16, 32'h8646_8006, 1'b0, "R7 cache type unchanged");

        // R12 unimplemented reads
        rd(5'd20, 32'h0, 1'b1, "R12 unimpl 20");
        rd(5'd31, 32'h0, 1'b1, "R12 unimpl 31");
        rd(5'd18, 32'h0, 1'b1, "R12 unimpl 18");
        rd(5'd17, 32'h0020_0000, 1'b0, "R12 valid after error");

        // R13 same-cycle write and read
        @(negedge clk); #1;
        wr_en = 1'b1; rd_en = 1'b1; idx = 5'd10; wr_data = 32'h0000_ABCD;
        push(cyc, 32'h0000_0001, 0, "R13 read sees old");
        push(cyc + 1, 32'h0, 2, "R13 no stale");
        rd(5'd10, 32'h0000_ABCD, 1'b0, "R13 new value next cycle");

        // R1 / R2 warm reset with a colliding control write
        wr(5'd2, 32'h0000_0000, 1'b0, "R1 template write");
        wr(5'd0, 32'h1111_2222, 1'b0, "R1 identity write");
        @(negedge clk); #1;
        rst_n = 1'b0; wr_en = 1'b1; rd_en = 1'b0; idx = 5'd1; wr_data = 32'hFFFF_FFFF;
        push(cyc + 1, 32'h0, 2, "R2 no stale under warm reset");
        @(negedge clk); #1;
        rst_n = 1'b1; wr_en = 1'b0;
        rd(5'd0, 32'h1111_2222, 1'b0, "R1 identity kept");
        rd(5'd2, 32'h0000_0000, 1'b0, "R1 template kept");
        rd(5'd1, 32'h00C0_0070, 1'b0, "R2 ctrl from template, write lost");
        rd(5'd3, 32'h0000_0010, 1'b0, "R2 status user again");
        rd(5'd10, 32'h0000_0001, 1'b0, "R2 mailbox again");
        rd(5'd5, 32'h0, 1'b0, "R2 access again");
        rd(5'd6, 32'h0, 1'b0, "R2 fpstat again");
        wr(5'd1, 32'hFFFF_FFFF, 1'b1, "R3 ctrl write stale 3");
        rd(5'd1, 32'hF7FF_FFFF, 1'b0, "R3 nmfi kept clear");

        repeat (4) idle();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule